// File: doc/BRIEF.md
# Three-Bank Level Interrupt Controller with Shortcut Bits

This block gathers 72 level-sensitive interrupt sources into one IRQ line and one FIQ line. The sources are arranged in a base group of 8 lines and two wide groups of 32 lines each. Each group has its own enable mask, which software changes through a write-one-to-set register and a write-one-to-clear register on a small register bus. Each group also has a pending word that reads as raw source AND enable.

The base pending word is the one software reads first. It holds the eight base sources, one summary bit for each wide group, and copies of eleven chosen wide-group lines ("shortcuts"). A shortcut lets a handler find a frequent source without a second read. A pending shortcut line does not set its group's summary bit, and it is masked only by its own group's enable register. A FIQ control register selects any one raw source by a flat index and routes it to the FIQ output. That selection leaves the source's IRQ mask alone.

All outputs are registered: `irq`, `fiq` and `rd_data` each show the state one clock after the inputs that cause it. The `rd_data` port is loaded on every clock from the current `addr`.

Top module: `bank_irq_ctrl`

## Requirements
- R1: Register map (byte offsets): pending base 0x00, wide group 1 0x04, wide group 2 0x08; enable-set base 0x18, group 1 0x10, group 2 0x14; enable-clear base 0x24, group 1 0x1C, group 2 0x20; FIQ control 0x0C. `rd_data` shows the register at the `addr` presented one clock earlier. Enable-set offsets read back the current mask. Enable-clear offsets and unmapped offsets read zero.
- R2: A write to an enable-set offset enables every source whose data bit is 1. A write to an enable-clear offset disables every source whose data bit is 1. Data bits that are 0 change nothing.
- R3: A wide-group pending word reads as that group's raw sources AND its enable mask.
- R4: Base pending bits 7:0 are base sources AND the base enables. Bit 8 is set when any enabled, pending group-1 line that is not a shortcut is high. Bit 9 does the same for group 2.
- R5: Group-1 lines 7, 9, 10, 18 and 19, when enabled and pending, appear at base pending bits 10, 11, 12, 13 and 14. Group-2 lines 21, 22, 23, 24, 25 and 30 appear at bits 15 to 20 in the same order. Bits 31:21 read zero.
- R6: A pending shortcut line never sets its group's summary bit (bit 8 or 9).
- R7: The base enable mask is 8 bits wide. Writes to base enable offsets at bit 8 and above have no effect, so a shortcut is masked only through its own group's enable registers.
- R8: FIQ control bits 6:0 hold a source index and bit 7 enables the FIQ. Indices 0-31 select group-1 lines, 32-63 select group-2 lines and 64-71 select base lines; any index above 71 selects nothing. `fiq` is high one clock after the enabled, selected raw source is high. Bits 31:8 read zero.
- R9: `irq` is high one clock after any bit of the base pending word is set, and low one clock after the word is zero.
- R10: Synchronous reset clears all enable masks, the FIQ control register, `irq`, `fiq` and `rd_data`.
- R11: Routing a source to the FIQ does not change its IRQ masking; an enabled source routed to the FIQ drives both `irq` and `fiq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset for writes and reads |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data for the previous `addr` |
| src_base | input | 8 | Base-group level sources |
| src_g1 | input | 32 | Wide group 1 level sources |
| src_g2 | input | 32 | Wide group 2 level sources |
| irq | output | 1 | Combined registered IRQ |
| fiq | output | 1 | Registered FIQ for the selected source |

## Verification
A behavioural model built from shortcut index lists predicts `irq`, `fiq` and `rd_data` on every clock. The directed patterns follow that model. Single non-shortcut wide lines and single shortcut lines show whether the summary bit is suppressed and whether each shortcut lands in the right bit. Mixed patterns across both groups show whether copies land at the wrong group offset. Writes of all-ones to the base enable registers, followed by masking in the owning group, show whether the base bank can wrongly mask a shortcut. FIQ indices in each of the three ranges and one above 71 show whether the index order and the range cutoff are right. Reading the FIQ state together with `irq` shows that the IRQ masking is left in place.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int WORD_W  = 32;
  localparam int BASE_N  = 8;
  localparam int GRP_N   = 32;
  localparam int SC1_N   = 5;
  localparam int SC2_N   = 6;
  localparam int SC1_LINE [SC1_N] = '{7, 9, 10, 18, 19};
  localparam int SC2_LINE [SC2_N] = '{21, 22, 23, 24, 25, 30};
  localparam int SUM1_BIT = 8;
  localparam int SUM2_BIT = 9;
  localparam int SC1_LSB  = 10;
  localparam int SC2_LSB  = SC1_LSB + SC1_N;
  localparam int SRC_TOTAL = 2 * GRP_N + BASE_N;
  localparam int FIQ_IDX_W = 7;

  localparam int A_PEND0 = 'h00;
  localparam int A_PEND1 = 'h04;
  localparam int A_PEND2 = 'h08;
  localparam int A_FIQ   = 'h0C;
  localparam int A_SET1  = 'h10;
  localparam int A_SET2  = 'h14;
  localparam int A_SET0  = 'h18;
  localparam int A_CLR1  = 'h1C;
  localparam int A_CLR2  = 'h20;
  localparam int A_CLR0  = 'h24;

  function automatic logic [GRP_N-1:0] sc1_mask();
    logic [GRP_N-1:0] m;
    m = '0;
    for (int i = 0; i < SC1_N; i++) m[SC1_LINE[i]] = 1'b1;
    return m;
  endfunction

  function automatic logic [GRP_N-1:0] sc2_mask();
    logic [GRP_N-1:0] m;
    m = '0;
    for (int i = 0; i < SC2_N; i++) m[SC2_LINE[i]] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irqc_group_en.sv
module irqc_group_en #(
  parameter int W = 32,
  parameter int AW = 8,
  parameter logic [AW-1:0] SET_A = '0,
  parameter logic [AW-1:0] CLR_A = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  raw,
  output logic [W-1:0]  en,
  output logic [W-1:0]  pend
);
  always_ff @(posedge clk) begin
    if (rst) en <= '0;
    else if (we && addr == SET_A) en <= en | wdata;
    else if (we && addr == CLR_A) en <= en & ~wdata;
  end

  assign pend = raw & en;

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
    (we && addr == SET_A) |=> ((en & $past(wdata)) == $past(wdata))); // R2
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (we && addr == CLR_A) |=> ((en & $past(wdata)) == '0)); // R2
  AST_OTHER_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(we && (addr == SET_A || addr == CLR_A)) |=> $stable(en)); // R2
endmodule

// File: rtl/irqc_compose.sv
module irqc_compose
  import irqc_pkg::*;
(
  input  logic [BASE_N-1:0] pend0,
  input  logic [GRP_N-1:0]  pend1,
  input  logic [GRP_N-1:0]  pend2,
  output logic [WORD_W-1:0] word
);
  localparam logic [GRP_N-1:0] SC1_M = sc1_mask();
  localparam logic [GRP_N-1:0] SC2_M = sc2_mask();

  logic [SC1_N-1:0] sc1;
  logic [SC2_N-1:0] sc2;

  for (genvar g = 0; g < SC1_N; g++) begin : g_sc1
    assign sc1[g] = pend1[SC1_LINE[g]];
  end
  for (genvar g = 0; g < SC2_N; g++) begin : g_sc2
    assign sc2[g] = pend2[SC2_LINE[g]];
  end

  always_comb begin
    word = '0;
    word[BASE_N-1:0]       = pend0;
    word[SUM1_BIT]         = |(pend1 & ~SC1_M);
    word[SUM2_BIT]         = |(pend2 & ~SC2_M);
    word[SC1_LSB +: SC1_N] = sc1;
    word[SC2_LSB +: SC2_N] = sc2;
  end
endmodule

// File: rtl/irqc_fiq_sel.sv
module irqc_fiq_sel #(
  parameter int N_SRC = 72,
  parameter int IDX_W = 7,
  parameter int AW = 8,
  parameter logic [AW-1:0] CTRL_A = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]   wdata,
  input  logic [N_SRC-1:0] src,
  output logic [7:0]   ctrl,
  output logic         hit
);
  localparam int SPAN = 2 ** IDX_W;

  logic [SPAN-1:0]  padded;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) ctrl <= '0;
    else if (we && addr == CTRL_A) ctrl <= wdata;
  end

  assign idx    = ctrl[IDX_W-1:0];
  assign padded = SPAN'(src);
  assign hit    = ctrl[7] & padded[idx];
endmodule

// File: rtl/bank_irq_ctrl.sv
module bank_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic [7:0]        src_base,
  input  logic [31:0]       src_g1,
  input  logic [31:0]       src_g2,
  output logic              irq,
  output logic              fiq
);
  localparam logic [GRP_N-1:0] SC1_M = sc1_mask();

  logic [BASE_N-1:0] en0, pend0;
  logic [GRP_N-1:0]  en1, pend1, en2, pend2;
  logic [WORD_W-1:0] word;
  logic [7:0]        fctrl;
  logic              fiq_hit;

  irqc_group_en #(.W(BASE_N), .AW(ADDR_W),
    .SET_A(ADDR_W'(A_SET0)), .CLR_A(ADDR_W'(A_CLR0))) u_en0 (
    .clk(clk), .rst(rst), .we(wr_en), .addr(addr), .wdata(wr_data[BASE_N-1:0]),
    .raw(src_base), .en(en0), .pend(pend0));

  irqc_group_en #(.W(GRP_N), .AW(ADDR_W),
    .SET_A(ADDR_W'(A_SET1)), .CLR_A(ADDR_W'(A_CLR1))) u_en1 (
    .clk(clk), .rst(rst), .we(wr_en), .addr(addr), .wdata(wr_data),
    .raw(src_g1), .en(en1), .pend(pend1));

  irqc_group_en #(.W(GRP_N), .AW(ADDR_W),
    .SET_A(ADDR_W'(A_SET2)), .CLR_A(ADDR_W'(A_CLR2))) u_en2 (
    .clk(clk), .rst(rst), .we(wr_en), .addr(addr), .wdata(wr_data),
    .raw(src_g2), .en(en2), .pend(pend2));

  irqc_compose u_comp (.pend0(pend0), .pend1(pend1), .pend2(pend2), .word(word));

  irqc_fiq_sel #(.N_SRC(SRC_TOTAL), .IDX_W(FIQ_IDX_W), .AW(ADDR_W),
    .CTRL_A(ADDR_W'(A_FIQ))) u_fiq (
    .clk(clk), .rst(rst), .we(wr_en), .addr(addr), .wdata(wr_data[7:0]),
    .src({src_base, src_g2, src_g1}), .ctrl(fctrl), .hit(fiq_hit));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      fiq     <= 1'b0;
      rd_data <= '0;
    end else begin
      irq <= |word;
      fiq <= fiq_hit;
      case (addr)
        ADDR_W'(A_PEND0): rd_data <= word;
        ADDR_W'(A_PEND1): rd_data <= pend1;
        ADDR_W'(A_PEND2): rd_data <= pend2;
        ADDR_W'(A_SET0):  rd_data <= WORD_W'(en0);
        ADDR_W'(A_SET1):  rd_data <= en1;
        ADDR_W'(A_SET2):  rd_data <= en2;
        ADDR_W'(A_FIQ):   rd_data <= WORD_W'(fctrl);
        default:          rd_data <= '0;
      endcase
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (en0 == '0 && en1 == '0 && en2 == '0 && fctrl == '0)); // R10
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (word == '0) |=> !irq); // R9
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (pend0 != '0) |=> irq); // R9
  AST_FIQ_RANGE: assert property (@(posedge clk) disable iff (rst)
    fiq |-> ($past(fctrl[7]) && $past(fctrl[6:0]) < 7'(SRC_TOTAL))); // R8
  AST_SC_NO_SUM: assert property (@(posedge clk) disable iff (rst)
    ((pend1 & ~SC1_M) == '0) |-> !word[SUM1_BIT]); // R6
  AST_BASE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (addr == ADDR_W'(A_SET0)) |=> (rd_data[31:BASE_N] == '0)); // R7
endmodule

// File: tb/tb_bank_irq_ctrl.sv
module tb_bank_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [7:0]  src_base = '0;
  logic [31:0] src_g1 = '0, src_g2 = '0;
  logic        irq, fiq;

  int n_checks = 0;
  int n_fail = 0;
  bit armed = 0;

  bank_irq_ctrl #(.ADDR_W(8)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .src_base(src_base), .src_g1(src_g1), .src_g2(src_g2),
    .irq(irq), .fiq(fiq));

  always #(CLK_PERIOD / 2) clk = ~clk;

  // behavioural reference
  int sc1_q[$] = '{7, 9, 10, 18, 19};
  int sc2_q[$] = '{21, 22, 23, 24, 25, 30};
  logic [31:0] m_en0, m_en1, m_en2, m_fc;
  logic [31:0] e_rd;
  logic        e_irq, e_fiq;

  function automatic logic [31:0] model_word();
    logic [31:0] w, p1, p2;
    w = 0;
    p1 = src_g1 & m_en1;
    p2 = src_g2 & m_en2;
    w[7:0] = src_base & m_en0[7:0];
    foreach (sc1_q[i]) begin
      w[10 + i] = p1[sc1_q[i]];
      p1[sc1_q[i]] = 1'b0;
    end
    foreach (sc2_q[i]) begin
      w[15 + i] = p2[sc2_q[i]];
      p2[sc2_q[i]] = 1'b0;
    end
    w[8] = (p1 != 0);
    w[9] = (p2 != 0);
    return w;
  endfunction

  function automatic logic model_src(int idx);
    if (idx < 32) return src_g1[idx];
    if (idx < 64) return src_g2[idx - 32];
    if (idx < 72) return src_base[idx - 64];
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en0 = 0; m_en1 = 0; m_en2 = 0; m_fc = 0;
      e_rd = 0; e_irq = 0; e_fiq = 0;
    end else begin
      e_irq = (model_word() != 0);
      e_fiq = m_fc[7] && model_src(int'(m_fc[6:0]));
      case (addr)
        8'h00: e_rd = model_word();
        8'h04: e_rd = src_g1 & m_en1;
        8'h08: e_rd = src_g2 & m_en2;
        8'h18: e_rd = m_en0;
        8'h10: e_rd = m_en1;
        8'h14: e_rd = m_en2;
        8'h0C: e_rd = m_fc;
        default: e_rd = 0;
      endcase
      if (wr_en) begin
        case (addr)
          8'h18: m_en0 = (m_en0 | wr_data) & 32'hFF;
          8'h24: m_en0 = m_en0 & ~wr_data;
          8'h10: m_en1 = m_en1 | wr_data;
          8'h1C: m_en1 = m_en1 & ~wr_data;
          8'h14: m_en2 = m_en2 | wr_data;
          8'h20: m_en2 = m_en2 & ~wr_data;
          8'h0C: m_fc = wr_data & 32'hFF;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the reference
  always @(negedge clk) begin
    if (armed && !rst) begin
      check({31'b0, irq}, {31'b0, e_irq}, "R9 irq vs model");
      check({31'b0, fiq}, {31'b0, e_fiq}, "R8 fiq vs model");
      check(rd_data, e_rd, "R1 rd_data vs model");
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    @(negedge clk);
    check(rd_data, exp, tag);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({30'b0, irq, fiq}, 32'h0, "R10 outputs in reset");
    rst = 1'b0;
    armed = 1;
    // R10 reset state
    rd(8'h18, 32'h0, "R10 base enable after reset");
    rd(8'h10, 32'h0, "R10 group1 enable after reset");
    rd(8'h0C, 32'h0, "R10 fiq ctrl after reset");
    // R2 set and clear semantics
    wr(8'h10, 32'h0);
    rd(8'h10, 32'h0, "R2 zero write no effect");
    wr(8'h10, 32'h0000_00F1);
    wr(8'h10, 32'h0000_0100);
    rd(8'h10, 32'h0000_01F1, "R2 set accumulates");
    wr(8'h1C, 32'h0000_0001);
    rd(8'h10, 32'h0000_01F0, "R2 clear one bit");
    rd(8'h1C, 32'h0, "R1 clear offset reads zero");
    // R3 and R4 summary from non-shortcut line
    src_g1 = 32'h0000_0033;
    rd(8'h04, 32'h0000_0030, "R3 group1 pending masked");
    rd(8'h00, 32'h0000_0100, "R4 summary bit 8");
    check({31'b0, irq}, 32'h1, "R9 irq from summary");
    // R5 and R6 shortcut
    src_g1 = 32'h0000_0080;
    rd(8'h00, 32'h0000_0400, "R6 shortcut without summary");
    rd(8'h04, 32'h0000_0080, "R5 shortcut also in group word");
    // R5 group 2 shortcuts
    wr(8'h14, 32'hFFFF_FFFF);
    src_g2 = 32'h4020_0000;
    rd(8'h00, 32'h0010_8400, "R5 group2 shortcut bits 15 and 20");
    rd(8'h08, 32'h4020_0000, "R3 group2 pending");
    src_g2 = 32'h0000_0001;
    rd(8'h00, 32'h0000_0600, "R4 summary bit 9");
    // R7 base enable cannot reach shortcuts
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, 32'h0000_00FF, "R7 base enable 8 bits");
    src_g1 = 32'h0; src_g2 = 32'h0040_0000;
    wr(8'h20, 32'h0040_0000);
    wr(8'h24, 32'hFFFF_FF00);
    rd(8'h00, 32'h0, "R7 shortcut masked by owning group only");
    settle();
    check({31'b0, irq}, 32'h0, "R9 irq low when word zero");
    wr(8'h14, 32'h0040_0000);
    rd(8'h00, 32'h0001_0000, "R7 shortcut re-enabled in group");
    src_g2 = 32'h0;
    src_base = 8'h81;
    rd(8'h00, 32'h0000_0081, "R4 base bits");
    wr(8'h24, 32'hFF);
    rd(8'h00, 32'h0, "R2 base clear");
    src_base = 8'h00;
    // R8 FIQ selector
    wr(8'h0C, 32'hFFFF_FF85);
    rd(8'h0C, 32'h0000_0085, "R8 ctrl upper bits zero");
    src_g1 = 32'h0000_0020;
    settle();
    check({31'b0, fiq}, 32'h1, "R8 fiq group1 index 5");
    src_g1 = 32'h0;
    settle(); settle();
    check({31'b0, fiq}, 32'h0, "R8 fiq drops with source");
    wr(8'h0C, 32'h80 | 70);
    src_base = 8'h40;
    settle(); settle();
    check({31'b0, fiq}, 32'h1, "R8 fiq base index 70");
    wr(8'h0C, 32'h80 | 100);
    src_base = 8'hFF; src_g1 = 32'hFFFF_FFFF; src_g2 = 32'hFFFF_FFFF;
    settle(); settle();
    check({31'b0, fiq}, 32'h0, "R8 index above 71 no fiq");
    wr(8'h0C, 32'h0000_0028);
    settle(); settle();
    check({31'b0, fiq}, 32'h0, "R8 fiq disabled bit 7");
    // R11 fiq does not touch irq mask
    src_base = 8'h00; src_g1 = 32'h0; src_g2 = 32'h0000_0100;
    wr(8'h0C, 32'h80 | 40);
    settle(); settle();
    check({30'b0, irq, fiq}, 32'h3, "R11 irq and fiq both asserted");
    rd(8'h14, 32'hFFFF_FFFF, "R11 group2 mask unchanged");
    repeat (4) settle();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule